// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block is the stall and operand-bypass controller for an in-order, six-stage pipeline. The stages run in order: fetch (FI), decode (DI), operand-address calculation (CO), operand fetch (FO), execute (EI) and write-back (WO). The unit tracks the control fields of every instruction in flight: a valid bit, a destination register, two source registers and a flag that says whether the instruction reads a memory operand in FO. The fetch side presents each new instruction's fields at the FI boundary. From the state it holds, the unit produces per-stage advance enables, the place where a bubble enters, a fetch inhibit and bypass selects for the instruction in FO.

The unit resolves two kinds of hazard. The first is a structural one: instruction fetch and operand fetch share a memory that serves one access per cycle. The second is a read-after-write dependency between a source in CO and the destination of an older instruction that has not finished. The `FWD_EN` parameter picks the dependency policy. With forwarding, a dependent instruction waits only until its producer has left EI and then takes the ALU result through the bypass. Without forwarding, it waits until the producer has completed write-back.

Top module: `hzd_interlock`

## Requirements
- R1: After reset no stage holds a valid instruction. All six advance enables are 1, fetch_hold is 0, bubble_ins is 0, both bypass selects are 0 and ret_valid is 0.
- R2: An instruction accepted at the FI boundary on clock edge E is in WO (ret_valid=1, ret_dst = its destination) during the cycle after edge E+4. Independent instructions retire one per cycle, in the order they were issued.
- R3: While the instruction in FO has its memory flag set, fetch_hold is 1 and bubble_ins[1] (bubble into DI) is 1 for that cycle. The instruction waiting at FI is delayed by exactly one cycle.
- R4: With FWD_EN=0, an instruction in CO whose source matches the destination of a valid instruction in FO or EI is held. Back-to-back this delays the consumer by 2 cycles and inserts 2 bubbles into FO (bubble_ins[3]). A producer two ahead costs 1 cycle. Bypass selects stay 0.
- R5: With FWD_EN=1, only a match against FO holds CO. Back-to-back this costs 1 cycle and inserts 1 bubble. When the instruction in FO has a source equal to the destination of the valid instruction in WO, byp_a (source A) or byp_b (source B) is 1 for that cycle. A producer two ahead costs 0 cycles.
- R6: During a hold, the held stage and every younger stage keep their contents: stage_adv[2:0] are 0 for a data hold, and stage_adv[0] is 0 for a memory hold. Older stages keep advancing, so the producer ahead of the hold retires on schedule and order is preserved.
- R7: A register number of 0, or a producer whose valid bit is 0, never causes a hold or a bypass.
- R8: When a memory conflict and a data dependency occur in the same cycle, the unit applies the union of both holds. Only one bubble position is active in any cycle.
- R9: A bubble inserted into DI reaches WO as ret_valid=0 five cycles later. A bubble inserted into FO reaches WO three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fi_valid | input | 1 | Instruction present at the fetch boundary |
| fi_dst | input | REG_W | Destination register of the fetched instruction (0 = none) |
| fi_src_a | input | REG_W | First source register (0 = unused) |
| fi_src_b | input | REG_W | Second source register (0 = unused) |
| fi_mem | input | 1 | Instruction reads a memory operand in FO |
| stage_adv | output | 6 | Advance enable per stage, bit 0 = FI through bit 5 = WO |
| bubble_ins | output | 6 | Bit k set: an empty slot enters stage k at the next edge |
| fetch_hold | output | 1 | Fetch inhibited; FI contents not accepted this cycle |
| byp_a | output | 1 | FO source A takes the forwarded ALU result |
| byp_b | output | 1 | FO source B takes the forwarded ALU result |
| ret_valid | output | 1 | Valid instruction in WO |
| ret_dst | output | REG_W | Destination register of the instruction in WO |

## Verification
The hardest case to reach is the cycle where a memory-operand producer in FO and its dependent consumer in CO stall together. Only one bubble position is active, and the fetch inhibit must hold for both reasons at once. The bench reaches this cycle by issuing a memory-flagged producer directly followed by its consumer. It then measures the consumer's retire gap on both a forwarding and a non-forwarding instance. The same directed sequences run on both instances, so each dependency distance is checked against the 2-cycle and the 1-cycle penalty.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NSTG  = 6;
  localparam int ST_FI = 0;
  localparam int ST_DI = 1;
  localparam int ST_CO = 2;
  localparam int ST_FO = 3;
  localparam int ST_EI = 4;
  localparam int ST_WO = 5;
endpackage

// File: rtl/hzd_slot.sv
module hzd_slot #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_self,
  input  logic             hold_prev,
  input  logic             in_valid,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_sa,
  input  logic [REG_W-1:0] in_sb,
  input  logic             in_mem,
  output logic             q_valid,
  output logic [REG_W-1:0] q_dst,
  output logic [REG_W-1:0] q_sa,
  output logic [REG_W-1:0] q_sb,
  output logic             q_mem
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_dst   <= '0;
      q_sa    <= '0;
      q_sb    <= '0;
      q_mem   <= 1'b0;
    end else if (!hold_self) begin
      // previous stage frozen while this one moves: take an empty slot
      q_valid <= in_valid && !hold_prev;
      q_dst   <= in_dst;
      q_sa    <= in_sa;
      q_sb    <= in_sb;
      q_mem   <= in_mem && !hold_prev;
    end
  end
endmodule

// File: rtl/hzd_detect.sv
module hzd_detect #(
  parameter int REG_W  = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic             co_v,
  input  logic [REG_W-1:0] co_sa,
  input  logic [REG_W-1:0] co_sb,
  input  logic             fo_v,
  input  logic             fo_m,
  input  logic [REG_W-1:0] fo_d,
  input  logic [REG_W-1:0] fo_sa,
  input  logic [REG_W-1:0] fo_sb,
  input  logic             ei_v,
  input  logic [REG_W-1:0] ei_d,
  input  logic             wo_v,
  input  logic [REG_W-1:0] wo_d,
  output logic             data_stall,
  output logic             mem_busy,
  output logic             byp_a,
  output logic             byp_b
);
  function automatic logic dep(input logic [REG_W-1:0] src,
                               input logic             pv,
                               input logic [REG_W-1:0] pd);
    return pv && (pd != '0) && (src == pd);
  endfunction

  logic hit_fo, hit_ei, fw_a, fw_b;

  assign hit_fo = dep(co_sa, fo_v, fo_d) || dep(co_sb, fo_v, fo_d);
  assign hit_ei = dep(co_sa, ei_v, ei_d) || dep(co_sb, ei_v, ei_d);
  assign fw_a   = fo_v && dep(fo_sa, wo_v, wo_d);
  assign fw_b   = fo_v && dep(fo_sb, wo_v, wo_d);

  assign mem_busy   = fo_v && fo_m;
  assign data_stall = co_v && (hit_fo || (!FWD_EN && hit_ei));
  assign byp_a      = FWD_EN && fw_a;
  assign byp_b      = FWD_EN && fw_b;
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fi_valid,
  input  logic [REG_W-1:0] fi_dst,
  input  logic [REG_W-1:0] fi_src_a,
  input  logic [REG_W-1:0] fi_src_b,
  input  logic             fi_mem,
  output logic [5:0]       stage_adv,
  output logic [5:0]       bubble_ins,
  output logic             fetch_hold,
  output logic             byp_a,
  output logic             byp_b,
  output logic             ret_valid,
  output logic [REG_W-1:0] ret_dst
);
  logic             sv [NSTG];
  logic [REG_W-1:0] sd [NSTG];
  logic [REG_W-1:0] ssa[NSTG];
  logic [REG_W-1:0] ssb[NSTG];
  logic             sm [NSTG];
  logic [NSTG-1:0]  hold;
  logic             data_stall, mem_busy;

  assign sv[ST_FI]  = fi_valid;
  assign sd[ST_FI]  = fi_dst;
  assign ssa[ST_FI] = fi_src_a;
  assign ssb[ST_FI] = fi_src_b;
  assign sm[ST_FI]  = fi_mem;

  genvar k;
  generate
    for (k = 1; k < NSTG; k++) begin : g_stage
      hzd_slot #(.REG_W(REG_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .hold_self(hold[k]),
        .hold_prev(hold[k-1]),
        .in_valid (sv[k-1]),
        .in_dst   (sd[k-1]),
        .in_sa    (ssa[k-1]),
        .in_sb    (ssb[k-1]),
        .in_mem   (sm[k-1]),
        .q_valid  (sv[k]),
        .q_dst    (sd[k]),
        .q_sa     (ssa[k]),
        .q_sb     (ssb[k]),
        .q_mem    (sm[k])
      );
    end
  endgenerate

  hzd_detect #(.REG_W(REG_W), .FWD_EN(FWD_EN)) u_detect (
    .co_v      (sv[ST_CO]),
    .co_sa     (ssa[ST_CO]),
    .co_sb     (ssb[ST_CO]),
    .fo_v      (sv[ST_FO]),
    .fo_m      (sm[ST_FO]),
    .fo_d      (sd[ST_FO]),
    .fo_sa     (ssa[ST_FO]),
    .fo_sb     (ssb[ST_FO]),
    .ei_v      (sv[ST_EI]),
    .ei_d      (sd[ST_EI]),
    .wo_v      (sv[ST_WO]),
    .wo_d      (sd[ST_WO]),
    .data_stall(data_stall),
    .mem_busy  (mem_busy),
    .byp_a     (byp_a),
    .byp_b     (byp_b)
  );

  // a data hold freezes CO and everything younger; a memory hold freezes fetch
  always_comb begin
    hold        = '0;
    hold[ST_CO] = data_stall;
    hold[ST_DI] = data_stall;
    hold[ST_FI] = data_stall || mem_busy;
  end

  always_comb begin
    bubble_ins = '0;
    for (int s = 1; s < NSTG; s++) bubble_ins[s] = hold[s-1] && !hold[s];
  end

  assign stage_adv  = ~hold;
  assign fetch_hold = hold[ST_FI];
  assign ret_valid  = sv[ST_WO];
  assign ret_dst    = sd[ST_WO];
endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [5:0]       stage_adv,
  input logic [5:0]       bubble_ins,
  input logic             fetch_hold,
  input logic             byp_a,
  input logic             byp_b,
  input logic             ret_valid,
  input logic [REG_W-1:0] ret_dst
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (!ret_valid && !fetch_hold && !byp_a && !byp_b));

  assert_fetch_bubble_flows_R9: assert property (@(posedge clk) disable iff (rst)
    bubble_ins[1] |-> ##5 !ret_valid);

  assert_fo_bubble_flows_R9: assert property (@(posedge clk) disable iff (rst)
    bubble_ins[3] |-> ##3 !ret_valid);

  assert_bypass_retires_R5: assert property (@(posedge clk) disable iff (rst)
    (byp_a || byp_b) |-> ##2 ret_valid);

  assert_younger_held_R6: assert property (@(posedge clk) disable iff (rst)
    !stage_adv[2] |-> (!stage_adv[1] && !stage_adv[0] && fetch_hold));

  assert_one_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bubble_ins));

  assert_ret_dst_known_R2: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> !$isunknown(ret_dst));
endmodule

bind hzd_interlock hzd_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stage_adv (stage_adv),
  .bubble_ins(bubble_ins),
  .fetch_hold(fetch_hold),
  .byp_a     (byp_a),
  .byp_b     (byp_b),
  .ret_valid (ret_valid),
  .ret_dst   (ret_dst)
);

// File: tb/hzd_interlock_test.sv
`timescale 1ns/1ps
module hzd_interlock_test;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  // index 0: forwarding instance, index 1: no-forwarding instance
  logic          fv [2];
  logic [RW-1:0] fd [2];
  logic [RW-1:0] fa [2];
  logic [RW-1:0] fb [2];
  logic          fm [2];
  logic [5:0]    adv[2];
  logic [5:0]    bub[2];
  logic          fh [2];
  logic          ba [2];
  logic          bb [2];
  logic          rv [2];
  logic [RW-1:0] rd [2];

  hzd_interlock #(.REG_W(RW), .FWD_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .fi_valid(fv[0]), .fi_dst(fd[0]), .fi_src_a(fa[0]),
    .fi_src_b(fb[0]), .fi_mem(fm[0]), .stage_adv(adv[0]), .bubble_ins(bub[0]),
    .fetch_hold(fh[0]), .byp_a(ba[0]), .byp_b(bb[0]), .ret_valid(rv[0]), .ret_dst(rd[0]));

  hzd_interlock #(.REG_W(RW), .FWD_EN(1'b0)) uut_nf (
    .clk(clk), .rst(rst), .fi_valid(fv[1]), .fi_dst(fd[1]), .fi_src_a(fa[1]),
    .fi_src_b(fb[1]), .fi_mem(fm[1]), .stage_adv(adv[1]), .bubble_ins(bub[1]),
    .fetch_hold(fh[1]), .byp_a(ba[1]), .byp_b(bb[1]), .ret_valid(rv[1]), .ret_dst(rd[1]));

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int rc [2][32];
  int n_ba[2], n_bb[2], n_bf[2], n_bd[2];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (!rst) begin
        if (rv[u]) rc[u][rd[u]] = cyc;
        if (ba[u]) n_ba[u]++;
        if (bb[u]) n_bb[u]++;
        if (bub[u][3]) n_bf[u]++;
        if (bub[u][1]) n_bd[u]++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts(input int u);
    n_ba[u] = 0; n_bb[u] = 0; n_bf[u] = 0; n_bd[u] = 0;
  endtask

  // present one instruction and wait until the fetch boundary accepts it
  task automatic issue(input int u, input logic v, input logic [RW-1:0] d,
                       input logic [RW-1:0] sa, input logic [RW-1:0] sb,
                       input logic m, output int acc);
    bit stalled;
    fv[u] = v; fd[u] = d; fa[u] = sa; fb[u] = sb; fm[u] = m;
    do begin
      stalled = fh[u];
      @(negedge clk);
    end while (stalled);
    acc = cyc;
  endtask

  task automatic drain(input int u);
    fv[u] = 1'b0; fd[u] = '0; fa[u] = '0; fb[u] = '0; fm[u] = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int u = 0; u < 2; u++) begin
      check("R1 ret_valid", int'(rv[u]), 0);
      check("R1 fetch_hold", int'(fh[u]), 0);
      check("R1 stage_adv", int'(adv[u]), 63);
      check("R1 bubble_ins", int'(bub[u]), 0);
      check("R1 bypass", int'(ba[u]) + int'(bb[u]), 0);
    end
  endtask

  task automatic t_stream(input int u);
    int a1, a2, a3, a4;
    clear_counts(u);
    issue(u, 1, 5'd1, 5'd20, 5'd21, 0, a1);
    issue(u, 1, 5'd2, 5'd22, 5'd0, 0, a2);
    issue(u, 1, 5'd3, 5'd0, 5'd23, 0, a3);
    issue(u, 1, 5'd4, 5'd24, 5'd25, 0, a4);
    drain(u);
    check("R2 latency", rc[u][1] - a1, 4);
    check("R2 gap 2-1", rc[u][2] - rc[u][1], 1);
    check("R2 gap 3-2", rc[u][3] - rc[u][2], 1);
    check("R2 gap 4-3", rc[u][4] - rc[u][3], 1);
    check("R2 no bubbles", n_bf[u] + n_bd[u], 0);
  endtask

  task automatic t_mem(input int u);
    int a;
    clear_counts(u);
    issue(u, 1, 5'd5, 5'd20, 5'd0, 1, a);
    issue(u, 1, 5'd6, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd7, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd8, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd9, 5'd0, 5'd0, 0, a);
    drain(u);
    check("R3 gap B-A", rc[u][6] - rc[u][5], 1);
    check("R3 gap C-B", rc[u][7] - rc[u][6], 1);
    check("R3 fetch delayed D-C", rc[u][8] - rc[u][7], 2);
    check("R3 gap E-D", rc[u][9] - rc[u][8], 1);
    check("R3 DI bubbles", n_bd[u], 1);
    check("R3 FO bubbles", n_bf[u], 0);
  endtask

  task automatic t_dep(input int u, input bit use_b);
    int a;
    bit fw = (u == 0);
    clear_counts(u);
    issue(u, 1, 5'd9, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd10, 5'd20, 5'd0, 0, a);
    if (use_b) issue(u, 1, 5'd11, 5'd0, 5'd10, 0, a);
    else       issue(u, 1, 5'd11, 5'd10, 5'd0, 0, a);
    issue(u, 1, 5'd12, 5'd0, 5'd0, 0, a);
    drain(u);
    check("R6 producer on time", rc[u][10] - rc[u][9], 1);
    if (fw) begin
      check("R5 back-to-back gap", rc[u][11] - rc[u][10], 2);
      check("R5 FO bubbles", n_bf[u], 1);
      check("R5 bypass A", n_ba[u], use_b ? 0 : 1);
      check("R5 bypass B", n_bb[u], use_b ? 1 : 0);
    end else begin
      check("R4 back-to-back gap", rc[u][11] - rc[u][10], 3);
      check("R4 FO bubbles", n_bf[u], 2);
      check("R4 no bypass", n_ba[u] + n_bb[u], 0);
    end
    check("R6 younger follows", rc[u][12] - rc[u][11], 1);
  endtask

  task automatic t_dist2(input int u);
    int a;
    bit fw = (u == 0);
    clear_counts(u);
    issue(u, 1, 5'd13, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd14, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd15, 5'd0, 5'd13, 0, a);
    drain(u);
    if (fw) begin
      check("R5 distance-2 gap", rc[u][15] - rc[u][14], 1);
      check("R5 distance-2 bypass B", n_bb[u], 1);
    end else begin
      check("R4 distance-2 gap", rc[u][15] - rc[u][14], 2);
      check("R4 distance-2 bubbles", n_bf[u], 1);
    end
  endtask

  task automatic t_zero(input int u);
    int a;
    clear_counts(u);
    issue(u, 1, 5'd16, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd0, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd17, 5'd0, 5'd0, 0, a);
    issue(u, 0, 5'd18, 5'd0, 5'd0, 0, a);
    issue(u, 1, 5'd19, 5'd18, 5'd0, 0, a);
    drain(u);
    check("R7 reg0 no hold", rc[u][17] - rc[u][16], 2);
    check("R7 invalid producer no hold", rc[u][19] - rc[u][17], 2);
    check("R7 no bubbles", n_bf[u], 0);
    check("R7 no bypass", n_ba[u] + n_bb[u], 0);
  endtask

  task automatic t_union(input int u);
    int a;
    bit fw = (u == 0);
    clear_counts(u);
    issue(u, 1, 5'd20, 5'd0, 5'd0, 1, a);
    issue(u, 1, 5'd21, 5'd20, 5'd0, 0, a);
    issue(u, 1, 5'd22, 5'd0, 5'd0, 0, a);
    drain(u);
    check("R8 consumer gap", rc[u][21] - rc[u][20], fw ? 2 : 3);
    check("R8 FO bubbles", n_bf[u], fw ? 1 : 2);
    check("R8 no DI bubble", n_bd[u], 0);
    check("R8 younger follows", rc[u][22] - rc[u][21], 1);
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      fv[u] = 0; fd[u] = '0; fa[u] = '0; fb[u] = '0; fm[u] = 0;
      clear_counts(u);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int u = 0; u < 2; u++) begin
      t_stream(u);
      t_mem(u);
      t_dep(u, 1'b0);
      t_dep(u, 1'b1);
      t_dist2(u);
      t_zero(u);
      t_union(u);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule